// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Vector Unit

This block joins two eight-input priority cells into one controller that serves fifteen interrupt sources. The first (primary) cell talks to the processor. The second (secondary) cell reports into position 2 of the primary cell. Line n of the sixteen-bit input bus goes to cell n/8 at local position n mod 8. Line 2 of the bus is not used, because its primary position is taken by the cascade.

Each line is edge-triggered or level-triggered, as set by a per-cell trigger register. A write to that register passes through a fixed mask of writable bits. The processor sees one interrupt line. It answers with a one-cycle acknowledge, and the unit returns an eight-bit vector with a one-cycle valid strobe. The vector is made of the upper five bits of the base of the cell that answered, followed by the local line number.

When the primary cell grants the cascade position, the secondary cell answers in the same cycle. If no real request stands behind a grant, the unit returns the spurious code 7 for the cell concerned. The processor interrupt line is worked out again from registered state after every acknowledge, request change and trigger write.

Top module: `pic_cascade_top`

## Requirements
- R1: Line n feeds cell n/8 at position n mod 8. Within a cell, the lowest pending position wins. Bus line 2 has no effect on any output.
- R2: In edge mode (trigger bit 0), a 0-to-1 change on a line makes it pending one clock later. It stays pending after the line falls, and it is cleared when it is acknowledged.
- R3: In level mode (trigger bit 1), a position is pending exactly while its line is high. An acknowledge does not clear it.
- R4: `trig_sel`=0 selects the primary cell and 1 selects the secondary cell. A write stores `trig_wdata` AND 8'hF8 for the primary cell and AND 8'hDE for the secondary cell. The stored values show on `primary_trig` and `secondary_trig` one clock after the write.
- R5: While the secondary cell has a pending request, primary position 2 becomes pending one clock later. This acts like an edge the primary cell latches once. `cpu_irq` is high exactly when the primary cell has a pending position.
- R6: `ack` held high for one clock edge gives `vec_valid`=1 for the following cycle. A primary win on position p≠2 gives `vector`={primary_base[7:3], p} and clears p if p is edge mode.
- R7: A primary win on position 2 while the secondary cell has a winner s gives `vector`={secondary_base[7:3], s}. It clears s if s is edge mode.
- R8: A primary win on position 2 with no secondary winner gives `vector`={secondary_base[7:3], 3'd7}. It clears primary position 2.
- R9: An acknowledge while `cpu_irq` is low gives `vector`={primary_base[7:3], 3'd7} and changes no request.
- R10: A new edge that arrives in the same cycle as the acknowledge of its own line is kept pending. Primary position 2 stays pending after a secondary acknowledge whenever other secondary requests remain.
- R11: After reset, `cpu_irq`, `vec_valid`, `vector`, `primary_trig` and `secondary_trig` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Interrupt request lines; bit 2 unused |
| ack | input | 1 | Processor acknowledge, one per clock edge |
| primary_base | input | 8 | Primary vector base; bits 2:0 ignored |
| secondary_base | input | 8 | Secondary vector base; bits 2:0 ignored |
| trig_we | input | 1 | Trigger register write enable |
| trig_sel | input | 1 | 0 primary, 1 secondary |
| trig_wdata | input | 8 | Trigger write data, 1 = level mode |
| cpu_irq | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector strobe, one cycle after ack |
| vector | output | 8 | Returned vector number |
| primary_trig | output | 8 | Stored primary trigger register |
| secondary_trig | output | 8 | Stored secondary trigger register |

## Verification
Two things can happen in the same edge. An acknowledge can clear a request while a new edge on that same line sets it again. An acknowledge of the cascade position can clear primary position 2 while the remaining secondary requests raise it again. The bench provokes the first by raising a line in the very cycle that acknowledges it, and expects two vectors for that line. It provokes the second by latching all fifteen sources at once and acknowledging back to back. There it expects the order 0, 1, secondary 0 to 7, then 3 to 7, with `cpu_irq` falling only after the last acknowledge.

// File: rtl/pic_cascade_pkg.sv
package pic_cascade_pkg;
   typedef enum logic [1:0] {
      ACK_PRIMARY   = 2'd0,
      ACK_SECONDARY = 2'd1,
      ACK_SEC_SPUR  = 2'd2,
      ACK_PRI_SPUR  = 2'd3
   } ack_kind_e;
endpackage

// File: rtl/pic_prio_cell.sv
module pic_prio_cell #(
   parameter int               LINES   = 8,
   parameter logic [LINES-1:0] TM_MASK = '1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [LINES-1:0]           lvl_i,
   input  logic [LINES-1:0]           force_i,
   input  logic [LINES-1:0]           clr_i,
   input  logic                       tm_we_i,
   input  logic [LINES-1:0]           tm_d_i,
   output logic [LINES-1:0]           tm_o,
   output logic [LINES-1:0]           irr_o,
   output logic                       win_vld_o,
   output logic [$clog2(LINES)-1:0]   win_idx_o
);
   localparam int IW = $clog2(LINES);

   logic [LINES-1:0] irr_q, last_q, tm_q, irr_d;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      assign irr_d[i] = tm_q[i]
         ? (lvl_i[i] | force_i[i])
         : ((irr_q[i] & ~clr_i[i]) | (lvl_i[i] & ~last_q[i]) | force_i[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q  <= '0;
         last_q <= '0;
         tm_q   <= '0;
      end else begin
         irr_q  <= irr_d;
         last_q <= lvl_i;
         if (tm_we_i) tm_q <= tm_d_i & TM_MASK;
      end
   end

   always_comb begin
      win_idx_o = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (irr_q[i]) win_idx_o = IW'(i);
      end
   end

   assign win_vld_o = |irr_q;
   assign irr_o     = irr_q;
   assign tm_o      = tm_q;
endmodule

// File: rtl/pic_cascade_top.sv
module pic_cascade_top #(
   parameter int       CELL_LINES = 8,
   parameter int       VEC_W      = 8,
   parameter int       CASC_POS   = 2,
   parameter logic [7:0] PRI_TM_MASK = 8'hF8,
   parameter logic [7:0] SEC_TM_MASK = 8'hDE
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [2*CELL_LINES-1:0] irq_lines,
   input  logic                    ack,
   input  logic [VEC_W-1:0]        primary_base,
   input  logic [VEC_W-1:0]        secondary_base,
   input  logic                    trig_we,
   input  logic                    trig_sel,
   input  logic [CELL_LINES-1:0]   trig_wdata,
   output logic                    cpu_irq,
   output logic                    vec_valid,
   output logic [VEC_W-1:0]        vector,
   output logic [CELL_LINES-1:0]   primary_trig,
   output logic [CELL_LINES-1:0]   secondary_trig
);
   import pic_cascade_pkg::*;

   localparam int IDX_W = $clog2(CELL_LINES);
   localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(CELL_LINES - 1);
   localparam logic [IDX_W-1:0] CASC_IDX = IDX_W'(CASC_POS);

   if (CELL_LINES != (1 << IDX_W)) begin : g_chk_lines
      $error("CELL_LINES must be a power of two");
   end
   if (CASC_POS >= CELL_LINES) begin : g_chk_casc
      $error("CASC_POS out of range");
   end
   if (VEC_W <= IDX_W) begin : g_chk_vec
      $error("VEC_W too small");
   end
   if (PRI_TM_MASK[CASC_POS] != 1'b0) begin : g_chk_mask
      $error("cascade position must stay edge mode");
   end

   logic [CELL_LINES-1:0] p_lvl, p_force, p_clr, p_irr;
   logic [CELL_LINES-1:0] s_lvl, s_clr, s_irr, s_tm;
   logic                  m_vld, s_vld;
   logic [IDX_W-1:0]      m_idx, s_idx;
   logic                  s_left;
   ack_kind_e             kind;

   always_comb begin
      p_lvl           = irq_lines[CELL_LINES-1:0];
      p_lvl[CASC_POS] = 1'b0;
      s_lvl           = irq_lines[2*CELL_LINES-1:CELL_LINES];
   end

   // acknowledge resolution and clear requests
   always_comb begin
      kind  = ACK_PRI_SPUR;
      p_clr = '0;
      s_clr = '0;
      if (m_vld) begin
         if (m_idx == CASC_IDX) begin
            p_clr[CASC_POS] = ack;
            if (s_vld) begin
               kind         = ACK_SECONDARY;
               s_clr[s_idx] = ack;
            end else begin
               kind = ACK_SEC_SPUR;
            end
         end else begin
            kind         = ACK_PRIMARY;
            p_clr[m_idx] = ack;
         end
      end
   end

   assign s_left = |(s_irr & ~(s_clr & ~s_tm));

   always_comb begin
      p_force           = '0;
      p_force[CASC_POS] = s_left;
   end

   pic_prio_cell #(.LINES(CELL_LINES), .TM_MASK(PRI_TM_MASK[CELL_LINES-1:0])) u_pri (
      .clk(clk), .rst_n(rst_n), .lvl_i(p_lvl), .force_i(p_force), .clr_i(p_clr),
      .tm_we_i(trig_we & ~trig_sel), .tm_d_i(trig_wdata), .tm_o(primary_trig),
      .irr_o(p_irr), .win_vld_o(m_vld), .win_idx_o(m_idx)
   );

   pic_prio_cell #(.LINES(CELL_LINES), .TM_MASK(SEC_TM_MASK[CELL_LINES-1:0])) u_sec (
      .clk(clk), .rst_n(rst_n), .lvl_i(s_lvl), .force_i('0), .clr_i(s_clr),
      .tm_we_i(trig_we & trig_sel), .tm_d_i(trig_wdata), .tm_o(s_tm),
      .irr_o(s_irr), .win_vld_o(s_vld), .win_idx_o(s_idx)
   );

   assign secondary_trig = s_tm;

   logic [VEC_W-1:0] vec_d;
   always_comb begin
      unique case (kind)
         ACK_PRIMARY:   vec_d = {primary_base[VEC_W-1:IDX_W], m_idx};
         ACK_SECONDARY: vec_d = {secondary_base[VEC_W-1:IDX_W], s_idx};
         ACK_SEC_SPUR:  vec_d = {secondary_base[VEC_W-1:IDX_W], SPUR_IDX};
         default:       vec_d = {primary_base[VEC_W-1:IDX_W], SPUR_IDX};
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vector    <= '0;
         vec_valid <= 1'b0;
      end else begin
         vec_valid <= ack;
         if (ack) vector <= vec_d;
      end
   end

   assign cpu_irq = m_vld;

   logic unused_bits;
   assign unused_bits = ^{primary_base[IDX_W-1:0], secondary_base[IDX_W-1:0],
                          irq_lines[CASC_POS], p_irr};
endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk #(
   parameter int         VEC_W    = 8,
   parameter int         IDX_W    = 3,
   parameter int         CASC_POS = 2,
   parameter logic [7:0] PRI_MASK = 8'hF8,
   parameter logic [7:0] SEC_MASK = 8'hDE
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ack,
   input logic             irq0,
   input logic             cpu_irq,
   input logic             vec_valid,
   input logic [VEC_W-1:0] vector,
   input logic [VEC_W-1:0] primary_base,
   input logic [VEC_W-1:0] secondary_base,
   input logic             trig_we,
   input logic             trig_sel,
   input logic [7:0]       trig_wdata,
   input logic [7:0]       primary_trig,
   input logic [7:0]       secondary_trig,
   input logic             m_vld,
   input logic [IDX_W-1:0] m_idx,
   input logic             s_vld,
   input logic [IDX_W-1:0] s_idx
);
   // R6
   strobe_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> vec_valid);
   // R6
   strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |=> !vec_valid);
   // R9
   pri_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !cpu_irq) |=> vector == {$past(primary_base[VEC_W-1:IDX_W]), {IDX_W{1'b1}}});
   // R8
   sec_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && m_vld && m_idx == IDX_W'(CASC_POS) && !s_vld)
      |=> vector == {$past(secondary_base[VEC_W-1:IDX_W]), {IDX_W{1'b1}}});
   // R7
   sec_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && m_vld && m_idx == IDX_W'(CASC_POS) && s_vld)
      |=> vector == {$past(secondary_base[VEC_W-1:IDX_W]), $past(s_idx)});
   // R4
   pri_trig_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_we && !trig_sel) |=> primary_trig == ($past(trig_wdata) & PRI_MASK));
   // R4
   sec_trig_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_we && trig_sel) |=> secondary_trig == ($past(trig_wdata) & SEC_MASK));
   // R5
   cascade_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_vld && !ack) |=> cpu_irq);
   // R2
   edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq0) |=> cpu_irq);
endmodule

bind pic_cascade_top pic_cascade_chk #(
   .VEC_W(8), .IDX_W(3), .CASC_POS(2), .PRI_MASK(8'hF8), .SEC_MASK(8'hDE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ack(ack), .irq0(irq_lines[0]), .cpu_irq(cpu_irq),
   .vec_valid(vec_valid), .vector(vector), .primary_base(primary_base),
   .secondary_base(secondary_base), .trig_we(trig_we), .trig_sel(trig_sel),
   .trig_wdata(trig_wdata), .primary_trig(primary_trig),
   .secondary_trig(secondary_trig), .m_vld(m_vld), .m_idx(m_idx),
   .s_vld(s_vld), .s_idx(s_idx)
);

// File: tb/sim_pic_cascade_top.sv
module sim_pic_cascade_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_lines = '0;
   logic        ack = 1'b0;
   logic [7:0]  primary_base = '0, secondary_base = '0;
   logic        trig_we = 1'b0, trig_sel = 1'b0;
   logic [7:0]  trig_wdata = '0;
   logic        cpu_irq, vec_valid;
   logic [7:0]  vector, primary_trig, secondary_trig;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pic_cascade_top u0 (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .ack(ack),
      .primary_base(primary_base), .secondary_base(secondary_base),
      .trig_we(trig_we), .trig_sel(trig_sel), .trig_wdata(trig_wdata),
      .cpu_irq(cpu_irq), .vec_valid(vec_valid), .vector(vector),
      .primary_trig(primary_trig), .secondary_trig(secondary_trig)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic pulse(input int n);
      irq_lines[n] = 1'b1;
      tick();
      irq_lines[n] = 1'b0;
   endtask

   task automatic do_ack();
      ack = 1'b1;
      tick();
      ack = 1'b0;
   endtask

   task automatic trig_write(input logic sel, input logic [7:0] d);
      trig_we = 1'b1; trig_sel = sel; trig_wdata = d;
      tick();
      trig_we = 1'b0;
   endtask

   function automatic logic [7:0] vec_of(input int line, input logic [7:0] pb, input logic [7:0] sb);
      if (line < 8) return (pb & 8'hF8) | 8'(line);
      return (sb & 8'hF8) | 8'(line - 8);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      // R11 reset state
      chk("R11 cpu_irq", {7'b0, cpu_irq}, 8'h00);
      chk("R11 vec_valid", {7'b0, vec_valid}, 8'h00);
      chk("R11 vector", vector, 8'h00);
      chk("R11 primary_trig", primary_trig, 8'h00);
      chk("R11 secondary_trig", secondary_trig, 8'h00);
      rst_n = 1'b1;
      tick();

      // R6 R7 R2: sweep every source in edge mode
      for (int n = 0; n < 16; n++) begin
         if (n == 2) continue;
         primary_base   = 8'h40 + 8'(n * 5);
         secondary_base = 8'h90 + 8'(n * 3);
         pulse(n);
         tick(); tick();
         chk(n < 8 ? "R2 pending" : "R5 cascade pending", {7'b0, cpu_irq}, 8'h01);
         do_ack();
         chk("R6 strobe", {7'b0, vec_valid}, 8'h01);
         chk(n < 8 ? "R6 vector" : "R7 vector", vector, vec_of(n, primary_base, secondary_base));
         chk("R2 cleared by ack", {7'b0, cpu_irq}, 8'h00);
         tick();
         chk("R6 strobe one cycle", {7'b0, vec_valid}, 8'h00);
      end

      // R1 bus line 2 ignored
      irq_lines[2] = 1'b1;
      repeat (4) tick();
      chk("R1 line 2 ignored", {7'b0, cpu_irq}, 8'h00);
      irq_lines[2] = 1'b0;
      tick();

      // R1 R10 priority order with cascade re-raise
      primary_base = 8'h08; secondary_base = 8'h18;
      irq_lines = 16'hFFFB;
      tick();
      irq_lines = '0;
      tick(); tick();
      for (int k = 0; k < 15; k++) begin
         int line;
         line = (k < 2) ? k : ((k < 10) ? k + 6 : k - 7);
         do_ack();
         chk(k >= 2 && k < 9 ? "R10 cascade kept" : "R1 priority", vector, vec_of(line, primary_base, secondary_base));
      end
      chk("R10 all drained", {7'b0, cpu_irq}, 8'h00);

      // R9 primary spurious
      do_ack();
      chk("R9 spurious vector", vector, 8'h0F);
      chk("R9 nothing raised", {7'b0, cpu_irq}, 8'h00);

      // R4 trigger write masks
      trig_write(1'b0, 8'hFF);
      chk("R4 primary mask", primary_trig, 8'hF8);
      trig_write(1'b1, 8'h21);
      chk("R4 secondary mask", secondary_trig, 8'h00);
      trig_write(1'b1, 8'hFF);
      chk("R4 secondary mask", secondary_trig, 8'hDE);

      // R3 level mode on primary line 3
      irq_lines[3] = 1'b1;
      tick();
      chk("R3 level pending", {7'b0, cpu_irq}, 8'h01);
      do_ack();
      chk("R3 vector", vector, 8'h0B);
      chk("R3 kept after ack", {7'b0, cpu_irq}, 8'h01);
      irq_lines[3] = 1'b0;
      tick();
      chk("R3 follows line", {7'b0, cpu_irq}, 8'h00);

      // R8 secondary spurious: level line 9 withdrawn
      irq_lines[9] = 1'b1;
      tick(); tick();
      irq_lines[9] = 1'b0;
      tick(); tick();
      chk("R8 cascade latched", {7'b0, cpu_irq}, 8'h01);
      do_ack();
      chk("R8 spurious vector", vector, 8'h1F);
      chk("R8 cascade cleared", {7'b0, cpu_irq}, 8'h00);

      // R10 edge arriving in its own acknowledge cycle
      pulse(0);
      tick();
      irq_lines[0] = 1'b1;
      do_ack();
      chk("R10 vector", vector, 8'h08);
      chk("R10 edge kept", {7'b0, cpu_irq}, 8'h01);
      do_ack();
      chk("R10 second vector", vector, 8'h08);
      chk("R10 no new edge", {7'b0, cpu_irq}, 8'h00);
      irq_lines[0] = 1'b0;
      tick();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule